// File: doc/BRIEF.md
# Split-Line Instruction Fetch Aligner

This block supplies a group of four consecutive instructions per cycle to a wide front end, even when the group runs past the end of a cache line. The instruction storage is divided into two banks: one holds the lower half of every line, the other holds the upper half. Because the two halves sit in separate banks, the block can read one half of the current line and, in the same cycle, the half that follows it. That second half is the upper half of the same line, or the lower half of the next line when the fetch address lies in the upper half of its line.

The words from both banks are joined into one window. The window is rotated so that the instruction at the fetch address lands in slot 0, and every slot carries a valid bit. A half-line becomes present when it is written through the fill port. When a needed half is absent, the group is cut short at the first missing word, and the reported next fetch address advances only by the number of slots delivered. The result is registered with one cycle of latency. A stall input freezes the registered output.

Top module: `split_fetch_aligner`

## Requirements
- R1: After reset, out_valid and out_slot_vld are 0, out_next_addr is 0, and every half-line in both banks is absent.
- R2: When fill_en is high at a clock edge, the half-line selected by fill_upper (0 = lower half, 1 = upper half) and fill_set is stored and becomes present. Word k of fill_data occupies bits [32k+31:32k].
- R3: fetch_addr is a word address. Bits [1:0] give the word within a half-line, bit 2 selects the half, and bits [5:3] give the set. Bits [15:6] do not affect which words are read.
- R4: When bit 2 of the address is 0, slot i carries word (addr[2:0]+i) of line addr[5:3]. Words 0 to 3 come from the lower half and words 4 to 7 from the upper half.
- R5: When bit 2 is 1, slots whose line word index (addr[2:0]+i) reaches 8 or more take word (addr[2:0]+i-8) from the lower half of the next set. The whole group is delivered in one fetch.
- R6: The set after set 7 is set 0.
- R7: A slot is valid only if the half-line that holds its word is present and every earlier slot is valid. If the half-line holding the first word is absent, no slot is valid.
- R8: out_slot_vld is always a contiguous run of ones that starts at slot 0, or all zeros.
- R9: out_next_addr equals the fetch address plus the number of valid slots, modulo 2^16.
- R10: Outputs appear one clock after the fetch is presented. With fetch_valid low, the next output has out_valid = 0, out_slot_vld = 0 and out_next_addr equal to fetch_addr.
- R11: While stall is high, all outputs keep their values, and the fetch inputs presented during the stall have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_en | input | 1 | Write one half-line into a bank |
| fill_upper | input | 1 | Bank select for the fill: 0 lower half, 1 upper half |
| fill_set | input | 3 | Set written by the fill |
| fill_data | input | 128 | Four instruction words, word 0 in the low bits |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_addr | input | 16 | Word address of the first instruction |
| stall | input | 1 | Hold the registered output |
| out_valid | output | 1 | A fetch result is held |
| out_slots | output | 128 | Aligned slots, slot 0 in the low bits |
| out_slot_vld | output | 4 | Per-slot valid bits |
| out_next_addr | output | 16 | Next sequential fetch address |

## Verification
Fixed directed fetches place the start word at the head of a lower half, in the middle of a line, at the last word of a line, and in the last set. These cases tell the in-line path apart from the path that crosses into the next line and from the wrap from set 7 to set 0. Some half-lines are left unfilled on purpose, so that the short group and the empty group show whether the cut falls at the right word. Later fills of those halves show that the full width returns. Random addresses with random stalls and idle cycles, plus addresses that differ only in the tag bits or that overflow the 16-bit range, separate address decoding from next-address arithmetic and from the hold behaviour.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    localparam int XLEN    = 32;
    localparam int FETCH_W = 4;
    localparam int HALF_W  = 4;
    localparam int SETS    = 8;
    localparam int ADDR_W  = 16;

    localparam int OFF_W   = $clog2(HALF_W);
    localparam int SET_W   = $clog2(SETS);
    localparam int CNT_W   = $clog2(FETCH_W + 1);
    localparam int WIN_W   = 2 * HALF_W;
    localparam int WSEL_W  = $clog2(WIN_W);
    localparam int IDX_W   = $clog2(WIN_W + FETCH_W);
    localparam int TAG_W   = ADDR_W - SET_W - OFF_W - 1;

    typedef logic [XLEN-1:0]                 word_t;
    typedef logic [HALF_W-1:0][XLEN-1:0]     half_t;
    typedef logic [WIN_W-1:0][XLEN-1:0]      window_t;
    typedef logic [FETCH_W-1:0][XLEN-1:0]    group_t;
    typedef logic [FETCH_W-1:0]              mask_t;
    typedef logic [ADDR_W-1:0]               addr_t;
    typedef logic [SET_W-1:0]                set_t;
    typedef logic [OFF_W-1:0]                off_t;
    typedef logic [CNT_W-1:0]                cnt_t;

    typedef enum logic {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        set_t             set;
        logic             upper;
        off_t             off;
    } loc_t;

    typedef struct packed {
        logic   valid;
        group_t slots;
        mask_t  vld;
        addr_t  next;
    } fetch_out_t;

    function automatic set_t set_after(set_t s);
        return (s == set_t'(SETS - 1)) ? '0 : set_t'(s + 1'b1);
    endfunction

    function automatic cnt_t count_ones(mask_t m);
        cnt_t c;
        c = '0;
        for (int i = 0; i < FETCH_W; i++) begin
            c = c + cnt_t'(m[i]);
        end
        return c;
    endfunction

    function automatic logic is_prefix(mask_t m);
        mask_t p;
        p = m + mask_t'(1);
        return (m & p) == '0;
    endfunction

endpackage

// File: rtl/sfa_bank.sv
module sfa_bank
    import sfa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  set_t  wr_set,
    input  half_t wr_data,
    input  set_t  rd_set,
    output half_t rd_data,
    output logic  rd_present
);

    half_t            mem [SETS];
    logic [SETS-1:0]  present;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_set] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            present <= '0;
        end else if (wr_en) begin
            present[wr_set] <= 1'b1;
        end
    end

    assign rd_data    = mem[rd_set];
    assign rd_present = present[rd_set];

    AST_FILL_MARKS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> present[$past(wr_set)]); // R2

endmodule

// File: rtl/sfa_rotate.sv
module sfa_rotate
    import sfa_pkg::*;
(
    input  half_t  first_half,
    input  half_t  second_half,
    input  logic   first_ok,
    input  logic   second_ok,
    input  off_t   off,
    output group_t slots,
    output mask_t  vld
);

    window_t window;
    assign window = {second_half, first_half};

    for (genvar i = 0; i < FETCH_W; i++) begin : g_slot
        logic [IDX_W-1:0] idx;
        logic             in_first;
        logic             in_window;

        assign idx       = IDX_W'(off) + IDX_W'(i);
        assign in_first  = idx < IDX_W'(HALF_W);
        assign in_window = idx < IDX_W'(WIN_W);

        assign slots[i] = in_window ? window[idx[WSEL_W-1:0]] : '0;
        assign vld[i]   = in_first  ? first_ok :
                          in_window ? (first_ok & second_ok) : 1'b0;
    end

endmodule

// File: rtl/split_fetch_aligner.sv
module split_fetch_aligner
    import sfa_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fill_en,
    input  logic                    fill_upper,
    input  logic [SET_W-1:0]        fill_set,
    input  logic [HALF_W*XLEN-1:0]  fill_data,
    input  logic                    fetch_valid,
    input  logic [ADDR_W-1:0]       fetch_addr,
    input  logic                    stall,
    output logic                    out_valid,
    output logic [FETCH_W*XLEN-1:0] out_slots,
    output logic [FETCH_W-1:0]      out_slot_vld,
    output logic [ADDR_W-1:0]       out_next_addr
);

    loc_t  loc;
    set_t  rd_set  [2];
    half_t rd_half [2];
    logic  rd_ok   [2];

    assign loc = loc_t'(fetch_addr);

    // Lower-half bank moves to the next set when the start lies in the upper half.
    assign rd_set[BANK_LO] = loc.upper ? set_after(loc.set) : loc.set;
    assign rd_set[BANK_HI] = loc.set;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        sfa_bank u_bank (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (fill_en && (fill_upper == 1'(b))),
            .wr_set     (set_t'(fill_set)),
            .wr_data    (half_t'(fill_data)),
            .rd_set     (rd_set[b]),
            .rd_data    (rd_half[b]),
            .rd_present (rd_ok[b])
        );
    end

    half_t  first_half, second_half;
    logic   first_ok, second_ok;
    group_t rot_slots;
    mask_t  rot_vld;

    always_comb begin
        if (loc.upper) begin
            first_half  = rd_half[BANK_HI];
            first_ok    = rd_ok[BANK_HI];
            second_half = rd_half[BANK_LO];
            second_ok   = rd_ok[BANK_LO];
        end else begin
            first_half  = rd_half[BANK_LO];
            first_ok    = rd_ok[BANK_LO];
            second_half = rd_half[BANK_HI];
            second_ok   = rd_ok[BANK_HI];
        end
    end

    sfa_rotate u_rotate (
        .first_half  (first_half),
        .second_half (second_half),
        .first_ok    (first_ok),
        .second_ok   (second_ok),
        .off         (loc.off),
        .slots       (rot_slots),
        .vld         (rot_vld)
    );

    fetch_out_t nxt, cur;
    mask_t      take;

    always_comb begin
        take       = fetch_valid ? rot_vld : '0;
        nxt.valid  = fetch_valid;
        nxt.slots  = rot_slots;
        nxt.vld    = take;
        nxt.next   = fetch_addr + addr_t'(count_ones(take));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (!stall) begin
            cur <= nxt;
        end
    end

    assign out_valid     = cur.valid;
    assign out_slots     = cur.slots;
    assign out_slot_vld  = cur.vld;
    assign out_next_addr = cur.next;

    AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (rst)
        is_prefix(out_slot_vld)); // R8

    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_slot_vld == '0)); // R10

    AST_FETCH_LANDS: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !stall) |=> out_valid); // R10

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(out_slots) && $stable(out_slot_vld)
                   && $stable(out_next_addr) && $stable(out_valid))); // R11

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !stall) |=>
            (addr_t'(out_next_addr - $past(fetch_addr)) <= addr_t'(FETCH_W))); // R9

endmodule

// File: tb/split_fetch_aligner_test.sv
`timescale 1ns/1ps
module split_fetch_aligner_test;
    import sfa_pkg::*;

    localparam int LINE_W = 2 * HALF_W;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    fill_en = 1'b0;
    logic                    fill_upper = 1'b0;
    logic [SET_W-1:0]        fill_set = '0;
    logic [HALF_W*XLEN-1:0]  fill_data = '0;
    logic                    fetch_valid = 1'b0;
    logic [ADDR_W-1:0]       fetch_addr = '0;
    logic                    stall = 1'b0;
    logic                    out_valid;
    logic [FETCH_W*XLEN-1:0] out_slots;
    logic [FETCH_W-1:0]      out_slot_vld;
    logic [ADDR_W-1:0]       out_next_addr;

    always #10 clk = ~clk;

    split_fetch_aligner uut (
        .clk(clk), .rst(rst), .fill_en(fill_en), .fill_upper(fill_upper),
        .fill_set(fill_set), .fill_data(fill_data), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .stall(stall), .out_valid(out_valid),
        .out_slots(out_slots), .out_slot_vld(out_slot_vld),
        .out_next_addr(out_next_addr)
    );

    logic [XLEN-1:0] m_mem  [2][SETS][HALF_W];
    bit              m_pres [2][SETS];

    logic [XLEN-1:0]    e_slots [FETCH_W];
    logic [FETCH_W-1:0] e_vld;
    logic               e_valid;
    logic [ADDR_W-1:0]  e_next;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic model(input bit fv, input logic [ADDR_W-1:0] a);
        int base_set, pos, cnt;
        bit stop;
        base_set = int'(a[5:3]);
        pos      = int'(a[2:0]);
        stop = 1'b0;
        cnt  = 0;
        e_vld = '0;
        for (int i = 0; i < FETCH_W; i++) begin
            int w, ls, h;
            w  = pos + i;
            ls = (w < LINE_W) ? base_set : (base_set + 1) % SETS;
            w  = w % LINE_W;
            h  = w / HALF_W;
            e_slots[i] = m_mem[h][ls][w % HALF_W];
            if (fv && !stop && m_pres[h][ls]) begin
                e_vld[i] = 1'b1;
                cnt++;
            end else begin
                stop = 1'b1;
            end
        end
        e_valid = fv;
        e_next  = a + ADDR_W'(cnt);
    endtask

    task automatic check(input string tag);
        bit bad;
        bad = (out_valid !== e_valid) || (out_slot_vld !== e_vld)
              || (out_next_addr !== e_next);
        for (int i = 0; i < FETCH_W; i++) begin
            if (e_vld[i] && out_slots[i*XLEN +: XLEN] !== e_slots[i]) bad = 1'b1;
        end
        n_chk++;
        if (bad) begin
            n_fail++;
            $display("FAIL %s: valid=%0b/%0b mask=%b/%b next=%h/%h slot0=%h/%h (actual/expected)",
                     tag, out_valid, e_valid, out_slot_vld, e_vld, out_next_addr, e_next,
                     out_slots[XLEN-1:0], e_slots[0]);
        end
    endtask

    task automatic fill(input bit up, input int s);
        @(negedge clk);
        fetch_valid = 1'b0;
        stall       = 1'b0;
        fill_en     = 1'b1;
        fill_upper  = up;
        fill_set    = SET_W'(s);
        for (int k = 0; k < HALF_W; k++) begin
            logic [XLEN-1:0] w;
            w = {$urandom} ^ {8'hC0, 8'(s), 8'(up), 8'(k)};
            fill_data[k*XLEN +: XLEN] = w;
            m_mem[up][s][k] = w;
        end
        @(posedge clk);
        m_pres[up][s] = 1'b1;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    task automatic fetch(input bit fv, input logic [ADDR_W-1:0] a, input string tag);
        @(negedge clk);
        stall       = 1'b0;
        fetch_valid = fv;
        fetch_addr  = a;
        model(fv, a);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < SETS; s++) begin
                m_pres[b][s] = 1'b0;
                for (int k = 0; k < HALF_W; k++) m_mem[b][s][k] = '0;
            end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        e_valid = 1'b0; e_vld = '0; e_next = '0;
        check("R1 reset outputs");
        fetch(1'b1, 16'h0000, "R1 banks empty after reset");

        // Fill everything except lower half of set 3 and upper half of set 5.
        for (int s = 0; s < SETS; s++) begin
            if (s != 3) fill(1'b0, s);
            if (s != 5) fill(1'b1, s);
        end

        fetch(1'b1, 16'd0,  "R4 start of line");
        fetch(1'b1, 16'd10, "R4 mid line across halves");
        fetch(1'b1, 16'd38, "R5 cross into next line");
        fetch(1'b1, 16'd23, "R7 next lower half absent");
        fetch(1'b1, 16'd41, "R7 own upper half absent");
        fetch(1'b1, 16'd45, "R7 first half absent");
        fetch(1'b1, 16'd62, "R6 wrap to set 0");
        fetch(1'b1, 16'h8000 | 16'd62, "R3 tag bits ignored");
        fetch(1'b1, 16'hFFFE, "R9 next address wraps");
        fetch(1'b0, 16'h1234, "R10 idle fetch");

        // Stall: present a new fetch while stalled, outputs must hold.
        fetch(1'b1, 16'd12, "R11 before stall");
        @(negedge clk);
        stall = 1'b1; fetch_valid = 1'b1; fetch_addr = 16'd30;
        @(posedge clk); @(negedge clk);
        check("R11 hold with new fetch");
        fetch_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R11 hold with idle input");

        fill(1'b0, 3);
        fill(1'b1, 5);
        fetch(1'b1, 16'd23, "R2 filled half now delivered");
        fetch(1'b1, 16'd45, "R2 upper half now present");

        for (int n = 0; n < 400; n++) begin
            bit st, fv;
            logic [ADDR_W-1:0] a;
            st = ($urandom % 8) == 0;
            fv = ($urandom % 6) != 0;
            a  = ADDR_W'($urandom);
            @(negedge clk);
            stall = st; fetch_valid = fv; fetch_addr = a;
            if (!st) model(fv, a);
            @(posedge clk); @(negedge clk);
            check(st ? "R11 random stall" : "R5 random fetch");
        end
        stall = 1'b0;
        finish_run();
    end

endmodule